// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This block carries out single-bit operations on one operand: it picks a bit, reports whether that bit was zero, and then either leaves the operand as it was, inverts the bit, forces it to zero or forces it to one. The operand is either a full 32-bit data register or one byte from memory. The bit number is wrapped to the operand width, so only its low five bits count for a register and its low three bits count for a byte.

A sequencer drives the operation code, the bit number, the operand and two qualifiers, then pulses `start` for one clock. One clock later the unit presents its results together with a one-cycle `done` pulse. The results are the new operand value, a write strobe, the new zero flag and the number of bus cycles the operation costs. No other condition flag is produced, so the caller's other flags stay as they were. Between operations the result, flag and cost outputs hold their last values.

Top module: `bit_modify_unit`

## Requirements
- R1: With operation code 1 (flip), `result` equals the operand with the selected bit inverted and every other operand bit unchanged.
- R2: With operation code 2 (clear), `result` equals the operand with the selected bit forced to 0.
- R3: With operation code 3 (set), `result` equals the operand with the selected bit forced to 1.
- R4: With operation code 0 (test), `result` equals the unmodified operand and no write-back is requested.
- R5: When `dest_is_mem` is 0, the operand is all 32 bits of `dest_val` and the bit number is taken modulo 32 (for example, 33 selects bit 1).
- R6: When `dest_is_mem` is 1, the operand is `dest_val[7:0]`, the bit number is taken modulo 8 (for example, 11 selects bit 3), and `result[31:8]` is 0.
- R7: `z_flag` is 1 when the selected bit of the original operand was 0, and 0 when it was 1. This holds whatever the operation code is.
- R8: `wr_en` is 1 only in the `done` cycle of an operation with code 1, 2 or 3, and is 0 at every other time.
- R9: With a bit number taken from a register (`num_is_imm` = 0), `cycles` is 8 for flip, set and clear and 4 for test. Test and clear add 2 when the destination is a register.
- R10: With an immediate bit number (`num_is_imm` = 1), `cycles` is 12 for flip, set and clear and 8 for test. Test and clear add 2 when the destination is a register.
- R11: `done` is high for exactly the one clock after each clock in which `start` is high. Without a new `start`, `result`, `z_flag` and `cycles` hold their values.
- R12: After synchronous reset, `result`, `wr_en`, `z_flag`, `cycles` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that launches an operation |
| op | input | 2 | Operation: 0 test, 1 flip, 2 clear, 3 set |
| bit_num | input | 8 | Bit number before wrapping |
| dest_val | input | 32 | Destination operand; only bits 7:0 are used for a memory byte |
| dest_is_mem | input | 1 | 1: memory byte operand, 0: 32-bit register operand |
| num_is_imm | input | 1 | 1: bit number is an immediate, 0: it comes from a register |
| result | output | 32 | Operand after modification |
| wr_en | output | 1 | Write-back request, valid with `done` |
| z_flag | output | 1 | New zero flag (inverse of the tested bit) |
| cycles | output | 5 | Bus-cycle cost of the operation |
| done | output | 1 | Result-valid pulse, one clock after `start` |

## Verification
Each operation code is tried on two kinds of operand. In one, the selected bit is set among many other set bits; in the other, it is clear among many clear bits. This shows whether the change stays on one bit and whether the zero flag comes from the original value rather than from the result. Bit numbers of 31, 33 and 11 on register and byte operands show whether the bit number is wrapped to the correct width, and whether the upper bytes of a memory result are dropped. A sweep over all sixteen combinations of code, source form and destination width separates each entry of the cost table. An idle clock after every operation shows whether `done` and `wr_en` stay single pulses while the other outputs hold their values.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int CYC_W = 5;

    typedef enum logic [1:0] {
        OP_TEST = 2'd0,
        OP_FLIP = 2'd1,
        OP_CLR  = 2'd2,
        OP_SET  = 2'd3
    } bitop_e;

    typedef struct packed {
        logic [CYC_W-1:0] base_reg_src;
        logic [CYC_W-1:0] base_imm_src;
    } cost_pair_t;

    localparam cost_pair_t COST_MODIFY = '{base_reg_src: 5'd8, base_imm_src: 5'd12};
    localparam cost_pair_t COST_TEST   = '{base_reg_src: 5'd4, base_imm_src: 5'd8};
    localparam logic [CYC_W-1:0] WIDE_EXTRA = 5'd2;

    function automatic logic [CYC_W-1:0] op_cost(input bitop_e op,
                                                 input logic   imm,
                                                 input logic   wide);
        cost_pair_t       pair;
        logic [CYC_W-1:0] c;
        pair = (op == OP_TEST) ? COST_TEST : COST_MODIFY;
        c    = imm ? pair.base_imm_src : pair.base_reg_src;
        if (wide && (op == OP_TEST || op == OP_CLR))
            c = c + WIDE_EXTRA;
        return c;
    endfunction

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 8
) (
    input  logic [NUM_W-1:0]  bit_num,
    input  logic              is_mem,
    output logic [DATA_W-1:0] sel_mask,
    output logic [DATA_W-1:0] lane_mask
);
    localparam logic [DATA_W-1:0] BYTE_LANE = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    logic [NUM_W-1:0] idx;

    always_comb begin
        if (is_mem)
            idx = NUM_W'(bit_num % NUM_W'(BYTE_W));
        else
            idx = NUM_W'(bit_num % NUM_W'(DATA_W));
        sel_mask  = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
        lane_mask = is_mem ? BYTE_LANE : {DATA_W{1'b1}};
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bitop_e            op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] sel_mask,
    output logic [DATA_W-1:0] res,
    output logic              zero,
    output logic              wr
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign res[i] = !sel_mask[i]     ? operand[i]  :
                        (op == OP_FLIP)  ? ~operand[i] :
                        (op == OP_CLR)   ? 1'b0        :
                        (op == OP_SET)   ? 1'b1        :
                                           operand[i];
    end

    assign zero = ~|(operand & sel_mask);
    assign wr   = (op != OP_TEST);
endmodule

// File: rtl/bitop_cost.sv
module bitop_cost
    import bitop_pkg::*;
(
    input  bitop_e           op,
    input  logic             num_is_imm,
    input  logic             wide,
    output logic [CYC_W-1:0] cost
);
    assign cost = op_cost(op, num_is_imm, wide);
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [NUM_W-1:0]  bit_num,
    input  logic [DATA_W-1:0] dest_val,
    input  logic              dest_is_mem,
    input  logic              num_is_imm,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              z_flag,
    output logic [CYC_W-1:0]  cycles,
    output logic              done
);
    bitop_e            op_q;
    logic [DATA_W-1:0] sel_mask, lane_mask, operand, alu_res;
    logic              alu_zero, alu_wr;
    logic [CYC_W-1:0]  cost;

    assign op_q    = bitop_e'(op);
    assign operand = dest_val & lane_mask;

    bitop_mask #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_W(NUM_W)) u_mask (
        .bit_num  (bit_num),
        .is_mem   (dest_is_mem),
        .sel_mask (sel_mask),
        .lane_mask(lane_mask)
    );

    bitop_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (op_q),
        .operand (operand),
        .sel_mask(sel_mask),
        .res     (alu_res),
        .zero    (alu_zero),
        .wr      (alu_wr)
    );

    bitop_cost u_cost (
        .op        (op_q),
        .num_is_imm(num_is_imm),
        .wide      (!dest_is_mem),
        .cost      (cost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            wr_en  <= 1'b0;
            z_flag <= 1'b0;
            cycles <= '0;
            done   <= 1'b0;
        end else begin
            done  <= start;
            wr_en <= start && alu_wr;
            if (start) begin
                result <= alu_res;
                z_flag <= alu_zero;
                cycles <= cost;
            end
        end
    end
endmodule

// File: rtl/bitop_checker.sv
module bitop_checker
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [1:0]        op,
    input logic [NUM_W-1:0]  bit_num,
    input logic [DATA_W-1:0] dest_val,
    input logic              dest_is_mem,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              z_flag,
    input logic [CYC_W-1:0]  cycles,
    input logic              done
);
    logic [DATA_W-1:0] lane_now;
    assign lane_now = dest_is_mem ? {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {DATA_W{1'b1}};

    a_r11_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    a_r11_done_needs_start: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(z_flag) && $stable(cycles)));
    a_r8_write_only_with_done: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);
    a_r4_test_never_writes: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd0) |=> !wr_en);
    a_r4_test_keeps_value: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd0) |=> result == $past(dest_val & lane_now));
    a_r1_flip_one_bit: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd1) |=> $countones(result ^ $past(dest_val & lane_now)) == 1);
    a_r2_clear_no_new_ones: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd2) |=> $countones(result & ~$past(dest_val & lane_now)) == 0);
    a_r3_set_no_lost_ones: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd3) |=> $countones($past(dest_val & lane_now) & ~result) == 0);
    a_r6_mem_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (start && dest_is_mem) |=> result[DATA_W-1:BYTE_W] == '0);
    a_r7_zero_flag_zero_value: assert property (@(posedge clk) disable iff (rst)
        (start && (dest_val & lane_now) == '0) |=> z_flag);
endmodule

bind bit_modify_unit bitop_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_W(NUM_W)) u_bitop_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op         (op),
    .bit_num    (bit_num),
    .dest_val   (dest_val),
    .dest_is_mem(dest_is_mem),
    .result     (result),
    .wr_en      (wr_en),
    .z_flag     (z_flag),
    .cycles     (cycles),
    .done       (done)
);

// File: tb/tb_bit_modify_unit.sv
`timescale 1ns/1ps
module tb_bit_modify_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op;
    logic [7:0]  bit_num;
    logic [31:0] dest_val;
    logic        dest_is_mem;
    logic        num_is_imm;
    logic [31:0] result;
    logic        wr_en;
    logic        z_flag;
    logic [4:0]  cycles;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    bit_modify_unit dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .bit_num(bit_num),
        .dest_val(dest_val), .dest_is_mem(dest_is_mem), .num_is_imm(num_is_imm),
        .result(result), .wr_en(wr_en), .z_flag(z_flag), .cycles(cycles), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_cost(input logic [1:0] o, input logic imm, input logic mem);
        logic [4:0] c;
        if (o == 2'd0) c = imm ? 5'd8 : 5'd4;
        else           c = imm ? 5'd12 : 5'd8;
        if (!mem && (o == 2'd0 || o == 2'd2)) c = c + 5'd2;
        return c;
    endfunction

    // Drives one operation and checks every output in the done cycle and the idle cycle after it.
    task automatic run_op(input string req, input logic [1:0] o, input logic [7:0] n,
                          input logic [31:0] v, input logic mem, input logic imm);
        logic [31:0] base, exp_res;
        int          idx;
        base = mem ? (v & 32'hFF) : v;
        idx  = mem ? (n % 8) : (n % 32);
        case (o)
            2'd1:    exp_res = base ^ (32'd1 << idx);
            2'd2:    exp_res = base & ~(32'd1 << idx);
            2'd3:    exp_res = base | (32'd1 << idx);
            default: exp_res = base;
        endcase
        @(negedge clk);
        op = o; bit_num = n; dest_val = v; dest_is_mem = mem; num_is_imm = imm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dest_val = ~v;
        check(req, "result", result, exp_res);
        check("R7", "z_flag", {31'd0, z_flag}, {31'd0, ~base[idx]});
        check("R8", "wr_en", {31'd0, wr_en}, {31'd0, o != 2'd0});
        check(imm ? "R10" : "R9", "cycles", {27'd0, cycles}, {27'd0, exp_cost(o, imm, mem)});
        check("R11", "done", {31'd0, done}, 32'd1);
        @(negedge clk);
        check("R11", "done idle", {31'd0, done}, 32'd0);
        check("R8", "wr_en idle", {31'd0, wr_en}, 32'd0);
        check("R11", "result held", result, exp_res);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; op = 2'd0; bit_num = 8'd0;
        dest_val = 32'hFFFF_FFFF; dest_is_mem = 1'b0; num_is_imm = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", "result", result, 32'd0);
        check("R12", "flags", {29'd0, wr_en, z_flag, done}, 32'd0);
        check("R12", "cycles", {27'd0, cycles}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_test_op();
        run_op("R4", 2'd0, 8'd5, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_op("R4", 2'd0, 8'd5, 32'h0000_0000, 1'b0, 1'b1);
        run_op("R4", 2'd0, 8'd2, 32'h1234_56FB, 1'b1, 1'b0);
    endtask

    task automatic t_flip();
        run_op("R1", 2'd1, 8'd7, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_op("R1", 2'd1, 8'd7, 32'h0000_0000, 1'b1, 1'b1);
        run_op("R1", 2'd1, 8'd31, 32'h8000_0001, 1'b0, 1'b1);
    endtask

    task automatic t_clear();
        run_op("R2", 2'd2, 8'd31, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_op("R2", 2'd2, 8'd0, 32'h0000_0000, 1'b0, 1'b1);
        run_op("R2", 2'd2, 8'd4, 32'hABCD_EF5A, 1'b1, 1'b0);
    endtask

    task automatic t_set();
        run_op("R3", 2'd3, 8'd16, 32'h0000_0000, 1'b0, 1'b0);
        run_op("R3", 2'd3, 8'd6, 32'hFFFF_FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_wrap();
        run_op("R5", 2'd3, 8'd33, 32'h0000_0000, 1'b0, 1'b0);
        run_op("R5", 2'd1, 8'd255, 32'h7FFF_FFFF, 1'b0, 1'b1);
        run_op("R6", 2'd3, 8'd11, 32'hFFFF_FF00, 1'b1, 1'b0);
        run_op("R6", 2'd2, 8'd15, 32'hFFFF_FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_cost_sweep();
        for (int o = 0; o < 4; o++)
            for (int imm = 0; imm < 2; imm++)
                for (int mem = 0; mem < 2; mem++)
                    run_op(o == 0 ? "R4" : (o == 1 ? "R1" : (o == 2 ? "R2" : "R3")),
                           2'(o), 8'(o * 9 + imm), 32'h5A5A_A5A5, 1'(mem), 1'(imm));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_test_op();
        t_flip();
        t_clear();
        t_set();
        t_wrap();
        t_cost_sweep();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule